// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, and moves data from one to the other. Data can go straight across (the live path), or it can come from one of two storage registers, one for each direction. Each direction has a single control input that does two jobs. Its rising edge loads that direction's register. Its level chooses whether the far bus sees live data or the stored word.

A direction input and an active-low output enable decide which bus, if any, the block drives. Each bus is modelled as three signals: an input value, an output value and a drive-enable flag. No tri-state net is inside the block, and the pad logic around it joins the three.

While both buses are isolated, the registers can still load whatever is on their source buses. A word loaded this way can then be placed on a bus once that bus is enabled.

The select inputs are sampled on the system clock. A rising edge is a sample of 1 that follows a sample of 0. The block has a synchronous active-low reset.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While reset is held low, and on the first clock edge after reset, the block shows live data on both outputs. Here b_out equals a_in and a_out equals b_in, even if a select input is high during reset.
- R2: b_drv is 1 exactly when oe_n is 0 and dir is 1. a_drv is 1 exactly when oe_n is 0 and dir is 0. The two flags are never 1 at the same time.
- R3: When oe_n is 1 (isolation), a_drv and b_drv are both 0, whatever the values of dir and the select inputs.
- R4: At a clock edge where sel_ab is sampled 1 after it was sampled 0 at the previous edge, the A-to-B register loads a_in as it is at that edge.
- R5: The B-to-A register loads b_in in the same way on a rising edge of sel_ba. The two registers load independently, and both may load at the same edge.
- R6: After a clock edge at which sel_ab was sampled 1, b_out shows the A-to-B register. Otherwise b_out shows the live a_in, with no clock delay. a_out behaves the same way, using sel_ba, the B-to-A register and the live b_in.
- R7: A register loaded while oe_n is 1 keeps its word. That word appears on the driven bus once oe_n goes to 0, provided the select input is still high.
- R8: While a select input stays high, its register does not change and its output stays the same, even if the source bus changes. A new load needs the select to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oe_n | input | 1 | Output enable, active low; 1 isolates both buses |
| dir | input | 1 | 1 drives bus B from A, 0 drives bus A from B |
| sel_ab | input | 1 | A-to-B register load edge and stored/live choice |
| sel_ba | input | 1 | B-to-A register load edge and stored/live choice |
| a_in | input | 8 | Value seen on bus A |
| b_in | input | 8 | Value seen on bus B |
| a_out | output | 8 | Value offered to bus A |
| a_drv | output | 1 | Drive enable for bus A |
| b_out | output | 8 | Value offered to bus B |
| b_drv | output | 1 | Drive enable for bus B |

## Verification
The drive flags and the live path are combinational, so they take effect in the same cycle as the input change. A register load and the switch to the stored word take effect after the clock edge that samples the rising select. The bench changes all inputs on the falling edge. At each rising edge it updates its model of the registers and the previous select levels, then samples the outputs 2 ns later, before any input moves again. The stored word therefore becomes due one edge after the select is raised, and a live value is due as soon as the input changes.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the registered bus transceiver.
package xcvr_pkg;
    // Which bus, if any, the transceiver is currently driving.
    typedef enum logic [1:0] {
        XC_ISOLATE = 2'd0,
        XC_A_TO_B  = 2'd1,
        XC_B_TO_A  = 2'd2
    } xc_path_e;
endpackage

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
// One transfer direction.
// It samples the select input, loads the register on a sampled rising edge,
// and chooses stored or live data for the far bus.
// Assumes that sel is synchronous to clk, or has been synchronised before it
// reaches this module.
module xcvr_lane #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic         sel_q;
    logic [W-1:0] stored;
    logic         load;

    // A sampled 0-to-1 transition of sel.
    assign load = sel && !sel_q;

    // Register the select level and load the register on a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            stored <= '0;
        end else begin
            sel_q <= sel;
            if (load) begin
                stored <= din;
            end
        end
    end

    // Stored word once the select was high at the last edge, live data otherwise.
    assign dout = sel_q ? stored : din;

    AST_LOAD_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !sel_q) |=> (stored == $past(din))); // R4
    AST_NO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !sel_q) |=> $stable(stored)); // R8
endmodule

// File: rtl/xcvr_gate.sv
`timescale 1ns/1ps
// Drive-enable gating.
// It decodes the output enable and the direction into one active path.
// It is purely combinational, and at most one drive flag is set.
module xcvr_gate
    import xcvr_pkg::*;
(
    input  logic oe_n,
    input  logic dir,
    output logic a_drv,
    output logic b_drv
);
    xc_path_e path;

    // Choose the active path from enable and direction.
    always_comb begin
        if (oe_n) begin
            path = XC_ISOLATE;
        end else if (dir) begin
            path = XC_A_TO_B;
        end else begin
            path = XC_B_TO_A;
        end
    end

    assign b_drv = (path == XC_A_TO_B);
    assign a_drv = (path == XC_B_TO_A);
endmodule

// File: rtl/bus_xcvr_reg.sv
`timescale 1ns/1ps
// Registered bidirectional bus transceiver.
// It holds one lane per direction: lane 0 carries A to B and lane 1 carries
// B to A. A gate block produces the drive flags.
// Assumes that the pads outside this block join each value with its drive flag.
module bus_xcvr_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv
);
    localparam int LANES = 2;

    logic [W-1:0] lane_in  [LANES];
    logic [W-1:0] lane_out [LANES];
    logic         lane_sel [LANES];

    // Connect the lane inputs and outputs to the two buses.
    assign lane_in[0]  = a_in;
    assign lane_sel[0] = sel_ab;
    assign lane_in[1]  = b_in;
    assign lane_sel[1] = sel_ba;
    assign b_out = lane_out[0];
    assign a_out = lane_out[1];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_lane #(.W(W)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .sel  (lane_sel[g]),
            .din  (lane_in[g]),
            .dout (lane_out[g])
        );
    end

    xcvr_gate u_gate (
        .oe_n (oe_n),
        .dir  (dir),
        .a_drv(a_drv),
        .b_drv(b_drv)
    );

    AST_DRV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_drv && b_drv)); // R2
    AST_ISOLATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!a_drv && !b_drv)); // R3
    AST_LIVE_A2B: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_ab) |-> (b_out == a_in)); // R6
    AST_LIVE_B2A: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel_ba) |-> (a_out == b_in)); // R6
endmodule

// File: tb/bus_xcvr_reg_test.sv
`timescale 1ns/1ps
// Self-checking bench: a sweep over control levels and data, plus directed cases.
module bus_xcvr_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic [7:0] a_out, b_out;
    logic       a_drv, b_drv;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Model state, kept by the bench.
    logic [7:0] m_ab = '0, m_ba = '0;
    bit p_ab = 1'b0, p_ba = 1'b0;

    bus_xcvr_reg #(.W(8)) uut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model.
    task automatic check_all();
        chk(oe_n ? "R3 b_drv" : "R2 b_drv", {7'd0, b_drv}, {7'd0, (!oe_n && dir)});
        chk(oe_n ? "R3 a_drv" : "R2 a_drv", {7'd0, a_drv}, {7'd0, (!oe_n && !dir)});
        chk(p_ab ? "R4 b_out stored" : "R6 b_out live", b_out, p_ab ? m_ab : a_in);
        chk(p_ba ? "R5 a_out stored" : "R6 a_out live", a_out, p_ba ? m_ba : b_in);
    endtask

    // Drive inputs on the falling edge, update the model at the rising edge, then check.
    task automatic step(input bit oe, input bit dr, input bit sa, input bit sb,
                        input logic [7:0] av, input logic [7:0] bv);
        @(negedge clk);
        oe_n = oe; dir = dr; sel_ab = sa; sel_ba = sb; a_in = av; b_in = bv;
        @(posedge clk);
        if (!rst_n) begin
            m_ab = '0; m_ba = '0; p_ab = 1'b0; p_ba = 1'b0;
        end else begin
            if (sa && !p_ab) m_ab = av;
            if (sb && !p_ba) m_ba = bv;
            p_ab = sa; p_ba = sb;
        end
        #2;
        check_all();
    endtask

    initial begin
        // R1: a high select during reset must still show the live path.
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'h55, 8'h3C);
        step(1'b0, 1'b1, 1'b1, 1'b0, 8'h12, 8'hE7);
        chk("R1 b_out live in reset", b_out, 8'h12);
        chk("R1 a_out live in reset", a_out, 8'hE7);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        a_in = 8'h9A; b_in = 8'h47;
        @(posedge clk);
        #2;
        chk("R1 b_out after reset", b_out, 8'h9A);
        chk("R1 a_out after reset", a_out, 8'h47);

        // Sweep: every control combination with changing data (R2 R3 R4 R5 R6).
        for (int i = 0; i < 512; i++) begin
            step(i[4], i[5], i[2], i[3], 8'(i * 37 + 5), 8'(i * 91) ^ 8'hA3);
        end

        // R5: both registers load at the same edge.
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'hC3, 8'h2D);
        chk("R5 both b_out", b_out, 8'hC3);
        chk("R5 both a_out", a_out, 8'h2D);

        // R7: load while isolated, then enable each bus.
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 8'h02);
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h5C);
        chk("R7 no drive in isolation", {6'd0, a_drv, b_drv}, 8'h00);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 8'h22);
        chk("R7 b bus gets isolated load", b_out, 8'hAA);
        chk("R7 b_drv on", {7'd0, b_drv}, 8'h01);
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h33, 8'h44);
        chk("R7 a bus gets isolated load", a_out, 8'h5C);
        chk("R7 a_drv on", {7'd0, a_drv}, 8'h01);

        // R8: hold high while the input changes, then drop and raise for a new load.
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h0F);
        chk("R8 b_out held", b_out, 8'hAA);
        chk("R8 a_out held", a_out, 8'h5C);
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h66, 8'h0F);
        chk("R8 b_out live after drop", b_out, 8'h66);
        step(1'b0, 1'b1, 1'b1, 1'b1, 8'h77, 8'h0F);
        chk("R8 b_out new load", b_out, 8'h77);
        chk("R8 a_out still held", a_out, 8'h5C);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule